// File: doc/BRIEF.md
# Programmable Panel Timing Generator

This block produces the timing skeleton for a TFT display: horizontal and vertical sync, a data-enable strobe, the current pixel column and line, and four auxiliary control pulses that some panels need for gate clocking, power sequencing, start pulses and polarity reversal. Nothing about the timing is fixed in hardware. Each output edge pair comes from a 32-bit register that holds a start position in its upper half and an end position in its lower half. A pixel counter and a line counter are compared against these windows.

Software first writes the totals and the window registers. It then sets the enable bit in the control register with the stop bit clear. The counters advance once per cycle in which the pixel-clock enable is high. A stop request does not cut a frame short: the block finishes the frame it is in, parks its counters at zero and reports idle. Each auxiliary pulse may have an end position beyond the line total. Such a pulse carries over into the start of the following line. A control bit for each auxiliary output sets its polarity.

Top module: `panel_timing_gen`

## Requirements
- R1: A cycle with `wr_en` high writes `wr_data` into the register at `wr_addr`: 0 control, 1 totals, 2 horizontal sync window, 3 vertical sync window, 4 horizontal display window, 5 vertical display window, 6+i auxiliary window i. Every window register holds its start in bits [31:16] and its end in bits [15:0]. The totals register holds the line length in pixels in bits [31:16] and the frame length in lines in bits [15:0].
- R2: While running, `pos_x` advances by one on each cycle with `pix_ce` high. When `pos_x` reaches total-1 it returns to 0 and `pos_y` advances. When `pos_y` also reaches its total-1 it returns to 0.
- R3: While running, a cycle with `pix_ce` low changes no counter and no output.
- R4: While running, `hsync` is high exactly when `pos_x` lies in [start, end) of its window. `vsync` is high exactly when `pos_y` lies in [start, end) of its window.
- R5: `de` is high only when `pos_x` lies in the horizontal display window and `pos_y` lies in the vertical display window at the same time.
- R6: While running, auxiliary pulse i is asserted when `pos_x` lies in [start, end), or when `pos_x` plus the line total lies in [start, end). The second case lets an end value above the total extend the pulse into the next line.
- R7: Control bit 8+i set to 1 makes `aux[i]` active-low, so it reads 0 when asserted and 1 when not. Set to 0, the output is active-high.
- R8: Control bit 3 is enable and bit 4 is the stop request. When an idle block holds enable=1 and stop=0, it starts running on the clock edge after the control register is loaded, with both counters at 0. While the stop bit is set, the block stays idle.
- R9: When a running block sees stop=1 or enable=0, it keeps going until the pixel step that leaves the last pixel of the last line. It then turns idle with `idle` high.
- R10: While idle, `pos_x`, `pos_y`, `hsync`, `vsync` and `de` are 0, and each `aux[i]` sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 32 | Register write data |
| pix_ce | input | 1 | Pixel-clock enable, one pixel step per high cycle |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pos_x | output | CW (16) | Current pixel column |
| pos_y | output | CW (16) | Current line |
| aux | output | NUM_AUX (4) | Auxiliary panel-control pulses |
| idle | output | 1 | High while the generator is stopped |

## Verification
The bench uses the default parameters: 16-bit positions and four auxiliary outputs. It programs a tiny raster of 10 pixels by 6 lines, which keeps whole frames within a few dozen cycles. This makes several things short to reach: both wrap points, the frame-end stop, and an auxiliary window that runs past the line end into the next line. One auxiliary output is set active-low. Its inactive level is then visible both while idle and while running.

// File: rtl/ptg_pkg.sv
// Package: shared register indices and control bit positions for the
// panel timing generator. Assumes a 4-bit register index space.
package ptg_pkg;
    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] A_CTRL  = 4'd0;
    localparam logic [REG_AW-1:0] A_TOTAL = 4'd1;
    localparam logic [REG_AW-1:0] A_HSYNC = 4'd2;
    localparam logic [REG_AW-1:0] A_VSYNC = 4'd3;
    localparam logic [REG_AW-1:0] A_HACT  = 4'd4;
    localparam logic [REG_AW-1:0] A_VACT  = 4'd5;
    localparam logic [REG_AW-1:0] A_AUX0  = 4'd6;

    localparam int EN_BIT   = 3;
    localparam int STOP_BIT = 4;
    localparam int POL_LSB  = 8;
endpackage

// File: rtl/ptg_regs.sv
// Module: ptg_regs
// Holds the control bits, the totals word and every window word.
// Assumes one write per cycle. Register writes take effect on the next edge.
module ptg_regs
    import ptg_pkg::*;
#(
    parameter int NUM_AUX = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [REG_AW-1:0]         wr_addr,
    input  logic [31:0]               wr_data,
    output logic                      en_q,
    output logic                      stop_q,
    output logic [NUM_AUX-1:0]        pol_q,
    output logic [31:0]               total_q,
    output logic [31:0]               hsync_q,
    output logic [31:0]               vsync_q,
    output logic [31:0]               hact_q,
    output logic [31:0]               vact_q,
    output logic [NUM_AUX-1:0][31:0]  aux_q
);
    // Load control bits and the main timing words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            stop_q  <= 1'b0;
            pol_q   <= '0;
            total_q <= '0;
            hsync_q <= '0;
            vsync_q <= '0;
            hact_q  <= '0;
            vact_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    en_q   <= wr_data[EN_BIT];
                    stop_q <= wr_data[STOP_BIT];
                    pol_q  <= wr_data[POL_LSB +: NUM_AUX];
                end
                A_TOTAL: total_q <= wr_data;
                A_HSYNC: hsync_q <= wr_data;
                A_VSYNC: vsync_q <= wr_data;
                A_HACT:  hact_q  <= wr_data;
                A_VACT:  vact_q  <= wr_data;
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_AUX; i++) begin : g_aux
        localparam logic [REG_AW-1:0] MY_ADDR = A_AUX0 + REG_AW'(i);
        // Load auxiliary window word i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                aux_q[i] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
                aux_q[i] <= wr_data;
        end
    end
endmodule

// File: rtl/ptg_counters.sv
// Module: ptg_counters
// Pixel and line counters plus the run/idle state.
// A stop request ends the run only on the step that leaves the last pixel
// of the last line. A total of 0 or 1 wraps on every step.
module ptg_counters #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_ce,
    input  logic          run_req,
    input  logic [CW-1:0] htot,
    input  logic [CW-1:0] vtot,
    output logic [CW-1:0] h,
    output logic [CW-1:0] v,
    output logic          running
);
    localparam logic [CW:0] ONE = (CW+1)'(1);

    logic h_last, v_last;

    // Detect the final pixel of a line and the final line of a frame.
    always_comb begin
        h_last = ({1'b0, h} + ONE) >= {1'b0, htot};
        v_last = ({1'b0, v} + ONE) >= {1'b0, vtot};
    end

    // Step the counters and manage start/stop at frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            h       <= '0;
            v       <= '0;
        end else if (!running) begin
            h <= '0;
            v <= '0;
            if (run_req)
                running <= 1'b1;
        end else if (pix_ce) begin
            if (h_last) begin
                h <= '0;
                if (v_last) begin
                    v <= '0;
                    if (!run_req)
                        running <= 1'b0;
                end else begin
                    v <= v + 1'b1;
                end
            end else begin
                h <= h + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ptg_window.sv
// Module: ptg_window
// Tests whether a position lies in a packed [start, end) window.
// Start is in bits [16 +: CW] and end in bits [0 +: CW].
// With EXTEND set, the position plus span is tested as well, so a window
// that ends past the span carries over into the next pass.
module ptg_window #(
    parameter int CW     = 16,
    parameter bit EXTEND = 1'b0
) (
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] span,
    input  logic [31:0]   win,
    output logic          hit
);
    logic [CW:0] p, pw, s, e;
    logic direct, carried;

    // Compare the plain and the span-shifted position with the window.
    always_comb begin
        p       = {1'b0, pos};
        pw      = p + {1'b0, span};
        s       = {1'b0, win[16 +: CW]};
        e       = {1'b0, win[0 +: CW]};
        direct  = (p >= s) && (p < e);
        carried = (pw >= s) && (pw < e);
        hit     = direct || (EXTEND && carried);
    end
endmodule

// File: rtl/panel_timing_gen.sv
// Module: panel_timing_gen (top)
// Software-programmed TFT timing generator. All edges come from packed
// start/end register pairs. Outputs are decoded from the counter registers
// and are forced to their resting levels while idle.
module panel_timing_gen
    import ptg_pkg::*;
#(
    parameter int CW      = 16,
    parameter int NUM_AUX = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_AW-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               pix_ce,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [CW-1:0]      pos_x,
    output logic [CW-1:0]      pos_y,
    output logic [NUM_AUX-1:0] aux,
    output logic               idle
);
    logic                     en_q, stop_q, running;
    logic [NUM_AUX-1:0]       pol_q, aux_hit;
    logic [31:0]              total_q, hsync_q, vsync_q, hact_q, vact_q;
    logic [NUM_AUX-1:0][31:0] aux_q;
    logic [CW-1:0]            h, v, htot, vtot;
    logic                     hs_hit, vs_hit, ha_hit, va_hit;

    assign htot = total_q[16 +: CW];
    assign vtot = total_q[0 +: CW];

    ptg_regs #(.NUM_AUX(NUM_AUX)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .en_q(en_q), .stop_q(stop_q), .pol_q(pol_q),
        .total_q(total_q), .hsync_q(hsync_q), .vsync_q(vsync_q),
        .hact_q(hact_q), .vact_q(vact_q), .aux_q(aux_q)
    );

    ptg_counters #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce),
        .run_req(en_q && !stop_q), .htot(htot), .vtot(vtot),
        .h(h), .v(v), .running(running)
    );

    ptg_window #(.CW(CW), .EXTEND(1'b0)) u_hs (
        .pos(h), .span(htot), .win(hsync_q), .hit(hs_hit));
    ptg_window #(.CW(CW), .EXTEND(1'b0)) u_vs (
        .pos(v), .span(vtot), .win(vsync_q), .hit(vs_hit));
    ptg_window #(.CW(CW), .EXTEND(1'b0)) u_ha (
        .pos(h), .span(htot), .win(hact_q), .hit(ha_hit));
    ptg_window #(.CW(CW), .EXTEND(1'b0)) u_va (
        .pos(v), .span(vtot), .win(vact_q), .hit(va_hit));

    for (genvar i = 0; i < NUM_AUX; i++) begin : g_aux
        ptg_window #(.CW(CW), .EXTEND(1'b1)) u_aw (
            .pos(h), .span(htot), .win(aux_q[i]), .hit(aux_hit[i]));
    end

    // Gate decoded windows with run state and apply aux polarity.
    always_comb begin
        hsync = running && hs_hit;
        vsync = running && vs_hit;
        de    = running && ha_hit && va_hit;
        aux   = ({NUM_AUX{running}} & aux_hit) ^ pol_q;
        pos_x = h;
        pos_y = v;
        idle  = !running;
    end
endmodule

// File: rtl/ptg_checker.sv
// Module: ptg_checker
// Temporal properties of the timing generator, attached by bind.
module ptg_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_ce,
    input logic          idle,
    input logic          hsync,
    input logic          vsync,
    input logic          de,
    input logic [CW-1:0] pos_x,
    input logic [CW-1:0] pos_y,
    input logic [31:0]   total_w,
    input logic [31:0]   vsync_w,
    input logic [31:0]   hact_w,
    input logic [31:0]   vact_w
);
    logic [CW:0] htot_x, vtot_x, px1, py1;
    assign htot_x = {1'b0, total_w[16 +: CW]};
    assign vtot_x = {1'b0, total_w[0 +: CW]};
    assign px1    = {1'b0, pos_x} + (CW+1)'(1);
    assign py1    = {1'b0, pos_y} + (CW+1)'(1);

    p_x_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && htot_x != '0) |-> ({1'b0, pos_x} < htot_x));

    p_ce_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !pix_ce) |=> ($stable(pos_x) && $stable(pos_y)));

    p_vs_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> (pos_y >= vsync_w[16 +: CW] && pos_y < vsync_w[0 +: CW]));

    p_de_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (pos_x >= hact_w[16 +: CW] && pos_x < hact_w[0 +: CW] &&
                pos_y >= vact_w[16 +: CW] && pos_y < vact_w[0 +: CW]));

    p_stop_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> ($past(px1) >= htot_x && $past(py1) >= vtot_x));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (pos_x == '0 && pos_y == '0 && !hsync && !vsync && !de));
endmodule

bind panel_timing_gen ptg_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .idle(idle),
    .hsync(hsync), .vsync(vsync), .de(de), .pos_x(pos_x), .pos_y(pos_y),
    .total_w(total_q), .vsync_w(vsync_q), .hact_w(hact_q), .vact_w(vact_q)
);

// File: tb/tb_panel_timing_gen.sv
// Bench: programs a 10x6 raster, walks a vector table, then runs directed
// tests for pixel-enable hold, frame-end stop, blocked start and restart.
module tb_panel_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pix_ce = 1'b1;
    logic        hsync, vsync, de, idle;
    logic [15:0] pos_x, pos_y;
    logic [3:0]  aux;

    int checks = 0;
    int fails  = 0;
    int kcur   = 0;

    always #10 clk = ~clk;

    panel_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync),
        .de(de), .pos_x(pos_x), .pos_y(pos_y), .aux(aux), .idle(idle)
    );

    // {step k, x, y, flags}; flags = {aux3,aux2,aux1,aux0,de,vsync,hsync}
    localparam int NV = 10;
    localparam logic [22:0] VEC [NV] = '{
        {8'd0,  4'd0, 4'd0, 7'h4B},
        {8'd1,  4'd1, 4'd0, 7'h6B},
        {8'd13, 4'd3, 4'd1, 7'h00},
        {8'd24, 4'd4, 4'd2, 7'h04},
        {8'd27, 4'd7, 4'd2, 7'h54},
        {8'd38, 4'd8, 4'd3, 7'h58},
        {8'd44, 4'd4, 4'd4, 7'h04},
        {8'd49, 4'd9, 4'd4, 7'h58},
        {8'd52, 4'd2, 4'd5, 7'h40},
        {8'd60, 4'd0, 4'd0, 7'h4B}
    };

    function automatic logic [31:0] snap();
        return {1'b0, idle, pos_x[7:0], pos_y[7:0], 7'b0,
                aux, de, vsync, hsync};
    endfunction

    function automatic logic [31:0] want(input logic i, input int x,
                                         input int y, input logic [6:0] f);
        return {1'b0, i, 8'(x), 8'(y), 7'b0, f};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step_to(input int k);
        while (kcur < k) begin
            @(negedge clk);
            kcur++;
        end
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state, idle with all outputs at rest
        check("R10 reset", snap(), want(1'b1, 0, 0, 7'h00));

        // R1: program raster 10x6 and windows
        wr(4'd1, 32'h000A_0006);
        wr(4'd2, 32'h0000_0002);
        wr(4'd3, 32'h0000_0001);
        wr(4'd4, 32'h0003_0008);
        wr(4'd5, 32'h0002_0005);
        wr(4'd6, 32'h0008_000C);
        wr(4'd7, 32'h0000_0005);
        wr(4'd8, 32'h0001_0002);
        wr(4'd9, 32'h0007_000D);
        wr(4'd0, 32'h0000_0200);
        @(negedge clk);
        // R7: aux1 set active-low rests at 1 while idle
        check("R7 idle polarity", snap(), want(1'b1, 0, 0, 7'h10));

        // R8: enable; control loads, running on next edge
        wr(4'd0, 32'h0000_0208);
        kcur = -1;
        for (int i = 0; i < NV; i++) begin
            step_to(int'(VEC[i][22:15]));
            check("R2 R4 R5 R6 R8 table", snap(),
                  want(1'b0, int'(VEC[i][14:11]), int'(VEC[i][10:7]),
                       VEC[i][6:0]));
        end

        // R3: pixel enable low holds everything
        pix_ce = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 hold", snap(), want(1'b0, 0, 0, 7'h4B));
        pix_ce = 1'b1;
        step_to(61);
        check("R3 resume", snap(), want(1'b0, 1, 0, 7'h6B));

        // R9: stop request mid-frame completes the frame
        step_to(65);
        wr(4'd0, 32'h0000_0218);
        kcur++;
        step_to(119);
        check("R9 still running at last pixel", snap(),
              want(1'b0, 9, 5, 7'h58));
        @(negedge clk);
        check("R9 R10 stopped at frame end", snap(),
              want(1'b1, 0, 0, 7'h10));

        // R8: stop bit set blocks a start
        repeat (5) @(negedge clk);
        check("R8 blocked by stop bit", snap(), want(1'b1, 0, 0, 7'h10));

        // R8: clearing stop restarts at origin
        wr(4'd0, 32'h0000_0208);
        @(negedge clk);
        check("R8 restart", snap(), want(1'b0, 0, 0, 7'h4B));

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule